// File: doc/BRIEF.md
# Serial Channel Wait/DMA Request Controller

This block drives the two per-channel handshake outputs of a serial communications controller. The shared pin is an open-drain output. It can stall the CPU with a bus wait, or it can ask a DMA engine for a transfer. The second pin can only act as a DMA request. Software programs both pins through an indexed register port. The block watches CPU accesses to the channel data registers together with the full and empty flags of the transmit and receive buffers. The serial shifters and the FIFOs lie outside the block and appear only as those two status inputs.

The CPU reaches a register in one of two ways. It can address the data register directly with the data select line. Otherwise it goes through a pointer: a control write made while the pointer is zero loads the pointer from the low data bits. The next control access then reaches the register the pointer names, and the pointer returns to zero when that access ends. Every pin output is registered on the falling edge of the clock. As a result, any assertion or release happens only on a falling edge. All bus inputs are assumed to be synchronous to the rising edge.

Top module: `serial_handshake_ctrl`

## Requirements
- R1: After the synchronous active-low reset both pin outputs are released. The pointer is cleared. The mode register holds enable = 0, function = wait, direction = transmit, and the second-pin request enable is cleared.
- R2: Register 1 holds the shared-pin mode: bit 7 enables the pin, bit 6 selects request (1) or wait (0), and bit 5 selects receive (1) or transmit (0). Registers are reached through the pointer: a control write while the pointer is 0 loads it from data bits 3:0, and the next control access uses it and then returns it to 0.
- R3: Writing the function and direction bits with enable = 0 leaves the shared pin released. The pin can change only on the later write that sets enable.
- R4: In transmit wait mode, a write to the transmit data register (register 8 through the pointer, or direct with data select) while the transmit buffer is full drives the shared pin low from the next falling edge. The pin stays driven until the buffer is no longer full.
- R5: In transmit wait mode the shared pin is never asserted by writes to other registers, by reads, or by a transmit data write made while the buffer has room.
- R6: In receive wait mode, a read of the receive data register while the receive buffer is empty drives the shared pin low from the next falling edge. The pin is released once data is present.
- R7: A change on either pin takes effect only at a falling clock edge. While the buffer condition clears, the pin keeps its old level until that edge.
- R8: In request mode the shared pin is driven while the transmit buffer is not full (transmit direction) or while the receive buffer is not empty (receive direction), and is released otherwise.
- R9: Bit 2 of register 14 enables the second pin as a transmit DMA request: it is driven while the transmit buffer is not full, independent of the shared pin.
- R10: Clearing the enable bit of register 1 releases the shared pin at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; outputs update on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select for the channel |
| bus_wr | input | 1 | Write strobe, held for the whole access |
| bus_rd | input | 1 | Read strobe, held for the whole access |
| bus_dsel | input | 1 | 1 = direct data register access, 0 = pointer-indexed control access |
| bus_wdata | input | 8 | Write data |
| tx_full | input | 1 | Transmit buffer full |
| rx_empty | input | 1 | Receive buffer empty |
| wreq_drive_low | output | 1 | Shared pin: 1 = pull low (active), 0 = released |
| aux_req_drive_low | output | 1 | Second pin: 1 = drive low (request active) |

## Verification
Assertions are checked on every clock and cover these rules: a waiting pin is released whenever its buffer condition is gone, a disabled mode keeps the shared pin quiet, an active wait holds while the transmit buffer stays full, and both request pins follow the buffer status. The bench scenarios cover the behaviour that depends on history and bus decoding. These include: which register a held strobe targets through the pointer, that reads and other register writes leave the pin alone, that the select write alone changes nothing, that the pin is still driven just after the buffer clears and drops only after the falling edge, and that a reset in mid-run restores the default wait-on-transmit fields.

// File: rtl/hs_pkg.sv
// Package hs_pkg
// Shared types for the serial handshake controller: the decoded mode of
// the shared wait/request pin and its reset value.
package hs_pkg;

    typedef struct packed {
        logic enable;   // pin function enabled
        logic req_sel;  // 1 = DMA request, 0 = CPU wait
        logic rx_dir;   // 1 = watch receive buffer, 0 = transmit buffer
    } hs_mode_t;

    localparam hs_mode_t HS_MODE_RESET = '{enable: 1'b0, req_sel: 1'b0, rx_dir: 1'b0};

endpackage

// File: rtl/hs_bus_decode.sv
// Module hs_bus_decode
// Decodes CPU accesses. It keeps the register pointer, flags the cycle in
// which a control write reaches the mode or auxiliary register, and flags,
// as levels, data register accesses for the wait logic.
// Assumes: strobes are held for the whole access and are synchronous to the
// rising clock edge; an access ends when both strobes or chip select drop.
module hs_bus_decode #(
    parameter int DATA_W   = 8,
    parameter int PTR_W    = 4,
    parameter int REG_MODE = 1,
    parameter int REG_DATA = 8,
    parameter int REG_AUX  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_dsel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              mode_we,
    output logic              aux_we,
    output logic              tx_access,
    output logic              rx_access
);

    localparam logic [PTR_W-1:0] MODE_IDX = PTR_W'(REG_MODE);
    localparam logic [PTR_W-1:0] DATA_IDX = PTR_W'(REG_DATA);
    localparam logic [PTR_W-1:0] AUX_IDX  = PTR_W'(REG_AUX);

    logic             acc;
    logic             acc_q;
    logic             acc_start;
    logic             acc_done;
    logic             ctrl_start;
    logic [PTR_W-1:0] ptr_q;
    logic             consume_q;
    logic             ptr_at_data;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Access edges derived from the held strobes.
    assign acc        = bus_cs && (bus_wr || bus_rd);
    assign acc_start  = acc && !acc_q;
    assign acc_done   = !acc && acc_q;
    assign ctrl_start = acc_start && !bus_dsel;

    // Remember whether an access was in progress on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= 1'b0;
        else        acc_q <= acc;
    end

    // Pointer: load on a control write at zero, consume on the next control access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            consume_q <= 1'b0;
        end else if (acc_done && consume_q) begin
            ptr_q     <= '0;
            consume_q <= 1'b0;
        end else if (ctrl_start) begin
            if (ptr_q == '0) begin
                if (bus_wr) ptr_q <= bus_wdata[PTR_W-1:0];
            end else begin
                consume_q <= 1'b0 | 1'b1;
            end
        end
    end

    // Register write strobes, one cycle at the start of the access.
    assign mode_we = ctrl_start && bus_wr && (ptr_q == MODE_IDX);
    assign aux_we  = ctrl_start && bus_wr && (ptr_q == AUX_IDX);

    // Data register targeting, directly or through the pointer.
    assign ptr_at_data = !bus_dsel && (ptr_q == DATA_IDX);
    assign tx_access   = bus_cs && bus_wr && (bus_dsel || ptr_at_data);
    assign rx_access   = bus_cs && bus_rd && (bus_dsel || ptr_at_data);

    // A control write can hit at most one configuration register.
    AST_SINGLE_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_we, aux_we})); // R2

    // A pointer-consuming access always returns the pointer to zero afterwards.
    AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && consume_q) |=> (ptr_q == '0)); // R2

endmodule

// File: rtl/hs_mode_regs.sv
// Module hs_mode_regs
// Holds the shared-pin mode register and the second-pin request enable.
// Fields are taken from fixed bit positions of the write data.
// Assumes: write strobes are single-cycle pulses from hs_bus_decode.
module hs_mode_regs
    import hs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int EN_BIT   = 7,
    parameter int FUNC_BIT = 6,
    parameter int DIR_BIT  = 5,
    parameter int AUX_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              aux_we,
    input  logic [DATA_W-1:0] wdata,
    output hs_mode_t          mode,
    output logic              aux_req_en
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Shared-pin mode register; the whole field set is written at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= HS_MODE_RESET;
        end else if (mode_we) begin
            mode.enable  <= wdata[EN_BIT];
            mode.req_sel <= wdata[FUNC_BIT];
            mode.rx_dir  <= wdata[DIR_BIT];
        end
    end

    // Second-pin request enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      aux_req_en <= 1'b0;
        else if (aux_we) aux_req_en <= wdata[AUX_BIT];
    end

endmodule

// File: rtl/hs_pin_engine.sv
// Module hs_pin_engine
// Computes the level of both pins and registers them on the falling clock
// edge, so every assertion and release lines up with that edge. A wait
// stays in force for as long as its buffer condition holds.
// Assumes: buffer flags and bus levels are stable across the falling edge.
module hs_pin_engine
    import hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hs_mode_t mode,
    input  logic     aux_req_en,
    input  logic     tx_access,
    input  logic     rx_access,
    input  logic     tx_full,
    input  logic     rx_empty,
    output logic     share_oe,
    output logic     aux_oe
);

    logic wait_tx;
    logic wait_rx;
    logic req_tx;
    logic req_rx;
    logic share_nxt;
    logic aux_nxt;

    // Decode which function currently owns the shared pin.
    assign wait_tx = mode.enable && !mode.req_sel && !mode.rx_dir;
    assign wait_rx = mode.enable && !mode.req_sel &&  mode.rx_dir;
    assign req_tx  = mode.enable &&  mode.req_sel && !mode.rx_dir;
    assign req_rx  = mode.enable &&  mode.req_sel &&  mode.rx_dir;

    // Next level of the shared pin: wait latches on a blocked access, request tracks status.
    always_comb begin
        share_nxt = 1'b0;
        if (wait_tx)      share_nxt = (tx_access || share_oe) && tx_full;
        else if (wait_rx) share_nxt = (rx_access || share_oe) && rx_empty;
        else if (req_tx)  share_nxt = !tx_full;
        else if (req_rx)  share_nxt = !rx_empty;
    end

    assign aux_nxt = aux_req_en && !tx_full;

    // Pin registers updated on the falling edge only.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            share_oe <= 1'b0;
            aux_oe   <= 1'b0;
        end else begin
            share_oe <= share_nxt;
            aux_oe   <= aux_nxt;
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.enable |-> !share_oe); // R3

    AST_TX_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_tx && !tx_full) |-> !share_oe); // R4

    AST_TX_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_tx && tx_full && $past(wait_tx) && $past(tx_full) && $past(share_oe))
        |-> share_oe); // R4

    AST_RX_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_rx && !rx_empty) |-> !share_oe); // R6

    AST_TX_REQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_tx |-> (share_oe == !tx_full)); // R8

    AST_RX_REQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_rx |-> (share_oe == !rx_empty)); // R8

    AST_AUX_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        aux_oe == (aux_req_en && !tx_full)); // R9

endmodule

// File: rtl/serial_handshake_ctrl.sv
// Module serial_handshake_ctrl
// Top of the per-channel wait/DMA request controller. Connects the bus
// decoder, the mode registers and the falling-edge pin engine.
// Assumes: bus inputs are synchronous to the rising clock edge; the pin
// outputs are open-drain enables, 1 meaning the pin is pulled low.
module serial_handshake_ctrl
    import hs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PTR_W    = 4,
    parameter int REG_MODE = 1,
    parameter int REG_DATA = 8,
    parameter int REG_AUX  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_dsel,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tx_full,
    input  logic              rx_empty,
    output logic              wreq_drive_low,
    output logic              aux_req_drive_low
);

    logic     mode_we;
    logic     aux_we;
    logic     tx_access;
    logic     rx_access;
    hs_mode_t mode;
    logic     aux_req_en;

    hs_bus_decode #(
        .DATA_W   (DATA_W),
        .PTR_W    (PTR_W),
        .REG_MODE (REG_MODE),
        .REG_DATA (REG_DATA),
        .REG_AUX  (REG_AUX)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_dsel  (bus_dsel),
        .bus_wdata (bus_wdata),
        .mode_we   (mode_we),
        .aux_we    (aux_we),
        .tx_access (tx_access),
        .rx_access (rx_access)
    );

    hs_mode_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .aux_we     (aux_we),
        .wdata      (bus_wdata),
        .mode       (mode),
        .aux_req_en (aux_req_en)
    );

    hs_pin_engine u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .aux_req_en (aux_req_en),
        .tx_access  (tx_access),
        .rx_access  (rx_access),
        .tx_full    (tx_full),
        .rx_empty   (rx_empty),
        .share_oe   (wreq_drive_low),
        .aux_oe     (aux_req_drive_low)
    );

    // A wait on transmit can only be entered when the data register is the target.
    AST_TX_WAIT_NEEDS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.enable && !mode.req_sel && !mode.rx_dir && !$past(wreq_drive_low)
         && $past(mode.enable) && !tx_access && !$past(tx_access))
        |-> !wreq_drive_low); // R5

endmodule

// File: tb/serial_handshake_ctrl_bench.sv
module serial_handshake_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_cs, bus_wr, bus_rd, bus_dsel;
    logic [7:0] bus_wdata;
    logic       tx_full, rx_empty;
    logic       wreq_drive_low, aux_req_drive_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic  oe;
        logic  r2;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_handshake_ctrl u_serial_handshake_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .bus_cs            (bus_cs),
        .bus_wr            (bus_wr),
        .bus_rd            (bus_rd),
        .bus_dsel          (bus_dsel),
        .bus_wdata         (bus_wdata),
        .tx_full           (tx_full),
        .rx_empty          (rx_empty),
        .wreq_drive_low    (wreq_drive_low),
        .aux_req_drive_low (aux_req_drive_low)
    );

    // Monitor: compares queued expectations shortly after each rising edge.
    always begin
        exp_t e;
        @(posedge clk);
        #2;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_tests++;
            if (wreq_drive_low !== e.oe || aux_req_drive_low !== e.r2) begin
                n_fail++;
                $display("FAIL %s: got oe=%0b r2=%0b, expected oe=%0b r2=%0b",
                         e.tag, wreq_drive_low, aux_req_drive_low, e.oe, e.r2);
            end
        end
    end

    task automatic expect_pins(input logic oe, input logic r2, input string tag);
        exp_t e;
        e.oe  = oe;
        e.r2  = r2;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_dsel = 1'b0; bus_wdata = d;
        tick();
        bus_cs = 1'b0; bus_wr = 1'b0;
        tick();
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
        wr_ctrl(idx);
        wr_ctrl(val);
    endtask

    initial begin
        rst_n = 1'b0; bus_cs = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_dsel = 1'b0; bus_wdata = 8'h00; tx_full = 1'b0; rx_empty = 1'b1;
        repeat (3) tick();
        expect_pins(1'b0, 1'b0, "R1 outputs during reset");
        rst_n = 1'b1;
        tick();
        expect_pins(1'b0, 1'b0, "R1 outputs after reset");

        // Default fields are wait/transmit: setting only enable selects it.
        tx_full = 1'b1;
        set_reg(8'd1, 8'h80);
        expect_pins(1'b0, 1'b0, "R2 enable without access");

        // Direct transmit data write while full.
        bus_cs = 1'b1; bus_wr = 1'b1; bus_dsel = 1'b1;
        expect_pins(1'b0, 1'b0, "R7 no wait before falling edge");
        tick();
        expect_pins(1'b1, 1'b0, "R4 wait on full transmit (direct)");
        tick();
        expect_pins(1'b1, 1'b0, "R4 wait held while full");
        tx_full = 1'b0;
        expect_pins(1'b1, 1'b0, "R7 still driven until falling edge");
        tick();
        expect_pins(1'b0, 1'b0, "R4 released after buffer drains");
        bus_cs = 1'b0; bus_wr = 1'b0;
        tick(); tick();

        // Other registers and reads never wait.
        tx_full = 1'b1;
        set_reg(8'd14, 8'h00);
        expect_pins(1'b0, 1'b0, "R5 aux register write while full");
        set_reg(8'd1, 8'h80);
        expect_pins(1'b0, 1'b0, "R5 mode register write while full");
        bus_cs = 1'b1; bus_rd = 1'b1; bus_dsel = 1'b1;
        tick();
        expect_pins(1'b0, 1'b0, "R5 data read in transmit wait");
        tick();
        expect_pins(1'b0, 1'b0, "R5 data read held");
        bus_cs = 1'b0; bus_rd = 1'b0;
        tick();

        // Transmit data write through the pointer.
        wr_ctrl(8'd8);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_dsel = 1'b0;
        tick();
        expect_pins(1'b1, 1'b0, "R4 wait via pointer to register 8");
        tx_full = 1'b0;
        tick();
        expect_pins(1'b0, 1'b0, "R4 pointer wait released");
        bus_cs = 1'b0; bus_wr = 1'b0;
        tick(); tick();

        // Write with room never waits.
        bus_cs = 1'b1; bus_wr = 1'b1; bus_dsel = 1'b1;
        tick();
        expect_pins(1'b0, 1'b0, "R5 write with room");
        tx_full = 1'b1;
        bus_cs = 1'b0; bus_wr = 1'b0;
        tick();
        expect_pins(1'b0, 1'b0, "R5 no wait after strobe ends");
        tx_full = 1'b0;
        tick();

        // Two-step programming of transmit request.
        rx_empty = 1'b0;
        set_reg(8'd1, 8'h40);
        expect_pins(1'b0, 1'b0, "R3 select write leaves pin released");
        tick();
        expect_pins(1'b0, 1'b0, "R3 still released");
        set_reg(8'd1, 8'hC0);
        expect_pins(1'b1, 1'b0, "R2 R8 transmit request with room");
        tx_full = 1'b1;
        expect_pins(1'b1, 1'b0, "R7 request unchanged before falling edge");
        tick();
        expect_pins(1'b0, 1'b0, "R8 full buffer drops request");
        tx_full = 1'b0;
        tick();
        expect_pins(1'b1, 1'b0, "R8 request returns");
        set_reg(8'd1, 8'h40);
        expect_pins(1'b0, 1'b0, "R10 disable releases pin");

        // Receive request.
        set_reg(8'd1, 8'h60);
        expect_pins(1'b0, 1'b0, "R3 receive select only");
        set_reg(8'd1, 8'hE0);
        expect_pins(1'b1, 1'b0, "R8 receive request with data");
        rx_empty = 1'b1;
        tick();
        expect_pins(1'b0, 1'b0, "R8 empty receive drops request");

        // Wait on receive.
        set_reg(8'd1, 8'h20);
        set_reg(8'd1, 8'hA0);
        expect_pins(1'b0, 1'b0, "R6 idle in receive wait");
        bus_cs = 1'b1; bus_rd = 1'b1; bus_dsel = 1'b1;
        tick();
        expect_pins(1'b1, 1'b0, "R6 wait on empty receive");
        tick();
        expect_pins(1'b1, 1'b0, "R6 wait held while empty");
        rx_empty = 1'b0;
        expect_pins(1'b1, 1'b0, "R7 receive wait held until falling edge");
        tick();
        expect_pins(1'b0, 1'b0, "R6 released when data arrives");
        bus_cs = 1'b0; bus_rd = 1'b0;
        tick();

        // Second pin.
        set_reg(8'd14, 8'h04);
        expect_pins(1'b0, 1'b1, "R9 second pin request");
        tx_full = 1'b1;
        tick();
        expect_pins(1'b0, 1'b0, "R9 second pin drops on full");
        tx_full = 1'b0;
        tick();
        expect_pins(1'b0, 1'b1, "R9 second pin returns");

        // Reset in mid-run restores defaults.
        rst_n = 1'b0;
        tick(); tick();
        expect_pins(1'b0, 1'b0, "R1 reset in mid-run");
        rst_n = 1'b1;
        tick();
        expect_pins(1'b0, 1'b0, "R1 second pin enable cleared");
        tx_full = 1'b1;
        set_reg(8'd1, 8'h80);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_dsel = 1'b1;
        tick();
        expect_pins(1'b1, 1'b0, "R1 reset restores wait-transmit fields");
        bus_cs = 1'b0; bus_wr = 1'b0; tx_full = 1'b0;
        tick(); tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule